// File: doc/BRIEF.md
# Four-Channel Overload Cut and Fast-Shutdown Controller

This block controls the power switches of four output channels. Each channel has an overcurrent comparator input, a current-limit fault input and a power-enable output. If a channel stays in overload for a set number of clock cycles, its fault flag sets and its power is removed. A per-channel mask can keep the power on while the flag still reports the fault. A current-limit fault always removes power. After any fault turn-off, a cool-down period blocks the channel from powering up again.

An external fast-shutdown strobe turns off a chosen subset of channels. The strobe is asynchronous, so the block synchronises it and acts on its rising edge. Each channel that shuts down this way gets a one-cycle clear-status pulse, which the surrounding status logic uses to clear that channel's status. Channels that are not selected are left exactly as they were. A shutdown does not cancel a running cool-down.

Channels 0/1 and 2/3 can be paired into 4-pair ports. When a pair's coupling bit is set, an overload cut on either channel turns off both. An 8-bit configuration byte, written and read over a simple register bus, holds the shutdown-select bits and the cut-mask bits.

Top module: `pcut_fss_ctrl`

## Requirements
- R1: The configuration byte is at bus address 0x15 and resets to 0x00. Bit 4+n selects channel n for fast shutdown. Bit n masks the overload cut of channel n. `cfg_rdata` shows the byte while `cfg_addr` is 0x15 and shows 0 otherwise. Writes to any other address have no effect.
- R2: While channel n is powered, its overload timer counts consecutive cycles with `ovl_in[n]` high. The fault flag rises on the edge that completes `OVLD_CYC` such cycles. A low cycle restarts the count.
- R3: With the cut mask at 0, power drops on the same edge that the fault flag sets, and the channel's cool-down (`COOL_CYC` cycles) begins.
- R4: With the cut mask at 1, the fault flag still sets after the timeout, but power stays on.
- R5: A register write that changes channel n's cut-mask bit restarts channel n's overload timer.
- R6: A high `ilim_in[n]` on a powered channel removes power on the next edge and starts the cool-down, whatever the mask is.
- R7: `fss_in` passes through two synchroniser flops. On the third rising clock edge after it goes high, every selected channel drops power, clears its fault flag and timer, and raises `clr_pulse` for exactly one cycle.
- R8: Channels whose select bit is 0 are not affected by the shutdown. With `prio_mode` at 1, no channel is affected at all.
- R9: A fast shutdown does not stop or restart a running cool-down. `cool_busy` keeps counting down as before.
- R10: With `pair_cut[p]` set, an overload cut on channel 2p or 2p+1 turns off both channels. Only the overloaded channel's flag sets. With the bit clear, each channel acts alone.
- R11: An unpowered channel powers on one edge after `pwr_req[n]` and `det_ok[n]` are both high while its cool-down is idle. Turn-off events take precedence over a power-on request.
- R12: `flag_clr[n]` clears the fault flag. A fault that sets the flag in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| prio_mode | input | 1 | Multi-bit priority mode; when 1, the shutdown-select bits have no effect |
| pair_cut | input | 2 | Per-port coupling of the overload cut |
| fss_in | input | 1 | Asynchronous fast-shutdown strobe |
| ovl_in | input | 4 | Per-channel overcurrent comparator |
| ilim_in | input | 4 | Per-channel current-limit fault |
| flag_clr | input | 4 | Per-channel fault flag clear |
| pwr_req | input | 4 | Per-channel power-on request |
| det_ok | input | 4 | Per-channel detection valid |
| pwr_en | output | 4 | Per-channel power enable |
| fault_flag | output | 4 | Per-channel overload fault flag |
| clr_pulse | output | 4 | Per-channel one-cycle clear-status request |
| cool_busy | output | 4 | Per-channel cool-down active |

## Verification
The assertions check on every cycle that:
- an unmasked cut, a current-limit fault or a paired cut removes power on the next edge;
- a masked fault sets the flag and leaves power on;
- a change to a mask bit zeroes the timer;
- a shutdown turns the channel off, clears its flag and pulses its clear output while the cool-down keeps counting;
- no channel powers on during its cool-down.

Some behaviour only the bench scenarios can show, because it depends on exact cycle counts and on register traffic:
- the timer fires on the exact cycle count, and one low cycle restarts it;
- writes to other addresses leave the byte unchanged;
- the shutdown takes effect three edges after the strobe goes high;
- power-on is refused until the cool-down has run out.

// File: rtl/pcut_pkg.sv
package pcut_pkg;

    localparam int NCH   = 4;
    localparam int NPAIR = NCH / 2;

    // shut_sel occupies the upper nibble, cut_dis the lower nibble
    typedef struct packed {
        logic [NCH-1:0] shut_sel;
        logic [NCH-1:0] cut_dis;
    } cfg_t;

    typedef enum logic [1:0] {
        OFF_NONE  = 2'd0,
        OFF_SHUT  = 2'd1,
        OFF_FAULT = 2'd2
    } off_e;

    function automatic logic [NCH-1:0] eff_sel(cfg_t c, logic prio);
        return prio ? '0 : c.shut_sel;
    endfunction

endpackage

// File: rtl/pcut_cfg_reg.sv
module pcut_cfg_reg
    import pcut_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [7:0]  CFG_ADDR = 8'h15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    input  logic [$bits(cfg_t)-1:0] wdata,
    output logic [$bits(cfg_t)-1:0] rdata,
    output cfg_t                cfg,
    output logic [NCH-1:0]      mask_chg
);

    logic hit;
    logic sel;
    cfg_t wcfg;
    cfg_t cfg_q;

    assign sel  = (addr == AW'(CFG_ADDR));
    assign hit  = wr && sel;
    assign wcfg = cfg_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (hit) begin
            cfg_q <= wcfg;
        end
    end

    assign mask_chg = hit ? (wcfg.cut_dis ^ cfg_q.cut_dis) : '0;
    assign rdata    = sel ? cfg_q : '0;
    assign cfg      = cfg_q;

endmodule

// File: rtl/pcut_fss_sync.sv
module pcut_fss_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fss_in,
    output logic fss_edge
);

    logic [SYNC_N:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[SYNC_N-1:0], fss_in};
        end
    end

    assign fss_edge = sh[SYNC_N-1] && !sh[SYNC_N];

    a_r7_edge_single: assert property (@(posedge clk) disable iff (rst)
        fss_edge |=> !fss_edge);

endmodule

// File: rtl/pcut_chan.sv
module pcut_chan
    import pcut_pkg::*;
#(
    parameter int OVLD_CYC = 16,
    parameter int COOL_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ovl,
    input  logic ilim,
    input  logic cut_dis,
    input  logic mask_chg,
    input  logic shut,
    input  logic partner_cut,
    input  logic pair_en,
    input  logic pwr_req,
    input  logic det_ok,
    input  logic flag_clr,
    output logic cut_fire,
    output logic pwr_en,
    output logic fault_flag,
    output logic clr_pulse,
    output logic cool_busy
);

    localparam int OW = $clog2(OVLD_CYC + 1);
    localparam int CW = $clog2(COOL_CYC + 1);
    localparam logic [OW-1:0] OV_LAST = OW'(OVLD_CYC - 1);

    logic [OW-1:0] ovl_cnt;
    logic [CW-1:0] cool_cnt;
    logic          pwr_q;
    logic          flag_q;
    logic          clr_q;
    logic          fire;
    logic          kill;
    off_e          off_cause;

    assign fire     = ovl && pwr_q && (ovl_cnt == OV_LAST);
    assign cut_fire = fire && !cut_dis;
    assign kill     = pwr_q && (cut_fire || (pair_en && partner_cut) || ilim);

    always_comb begin
        if (shut) begin
            off_cause = OFF_SHUT;
        end else if (kill) begin
            off_cause = OFF_FAULT;
        end else begin
            off_cause = OFF_NONE;
        end
    end

    // overload timer
    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_cnt <= '0;
        end else if (shut || mask_chg || !ovl || !pwr_q) begin
            ovl_cnt <= '0;
        end else if (ovl_cnt != OV_LAST) begin
            ovl_cnt <= ovl_cnt + OW'(1);
        end
    end

    // power state
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= 1'b0;
        end else begin
            case (off_cause)
                OFF_SHUT, OFF_FAULT: pwr_q <= 1'b0;
                default: begin
                    if (pwr_req && det_ok && (cool_cnt == '0)) begin
                        pwr_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // cool-down runs independently of shutdown
    always_ff @(posedge clk) begin
        if (rst) begin
            cool_cnt <= '0;
        end else if (kill) begin
            cool_cnt <= CW'(COOL_CYC);
        end else if (cool_cnt != '0) begin
            cool_cnt <= cool_cnt - CW'(1);
        end
    end

    // fault flag and clear request
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            clr_q <= shut;
            if (shut) begin
                flag_q <= 1'b0;
            end else if (fire) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign pwr_en     = pwr_q;
    assign fault_flag = flag_q;
    assign clr_pulse  = clr_q;
    assign cool_busy  = (cool_cnt != '0);

    a_r3_cut_drops_power: assert property (@(posedge clk) disable iff (rst)
        cut_fire |=> !pwr_q);

    a_r2_flag_on_timeout: assert property (@(posedge clk) disable iff (rst)
        fire && !shut |=> flag_q);

    a_r4_masked_keeps_power: assert property (@(posedge clk) disable iff (rst)
        fire && cut_dis && !shut && !ilim && !(pair_en && partner_cut) |=> pwr_q);

    a_r5_mask_restart: assert property (@(posedge clk) disable iff (rst)
        mask_chg |=> ovl_cnt == '0);

    a_r6_ilim_off: assert property (@(posedge clk) disable iff (rst)
        ilim && pwr_q |=> !pwr_q && cool_cnt != '0);

    a_r7_shut_clears: assert property (@(posedge clk) disable iff (rst)
        shut |=> !pwr_q && clr_q && !flag_q);

    a_r9_cool_kept: assert property (@(posedge clk) disable iff (rst)
        shut && !kill && cool_cnt != '0 |=> cool_cnt == $past(cool_cnt) - CW'(1));

    a_r11_no_on_in_cool: assert property (@(posedge clk) disable iff (rst)
        !pwr_q && cool_cnt != '0 |=> !pwr_q);

endmodule

// File: rtl/pcut_fss_ctrl.sv
module pcut_fss_ctrl
    import pcut_pkg::*;
#(
    parameter int          OVLD_CYC = 16,
    parameter int          COOL_CYC = 64,
    parameter int          SYNC_N   = 2,
    parameter logic [7:0]  CFG_ADDR = 8'h15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             prio_mode,
    input  logic [NPAIR-1:0] pair_cut,
    input  logic             fss_in,
    input  logic [NCH-1:0]   ovl_in,
    input  logic [NCH-1:0]   ilim_in,
    input  logic [NCH-1:0]   flag_clr,
    input  logic [NCH-1:0]   pwr_req,
    input  logic [NCH-1:0]   det_ok,
    output logic [NCH-1:0]   pwr_en,
    output logic [NCH-1:0]   fault_flag,
    output logic [NCH-1:0]   clr_pulse,
    output logic [NCH-1:0]   cool_busy
);

    cfg_t           cfg;
    logic [NCH-1:0] mask_chg;
    logic           fss_edge;
    logic [NCH-1:0] shut;
    logic [NCH-1:0] cut_fire;

    pcut_cfg_reg #(
        .AW       (8),
        .CFG_ADDR (CFG_ADDR)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .cfg      (cfg),
        .mask_chg (mask_chg)
    );

    pcut_fss_sync #(
        .SYNC_N (SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .fss_in   (fss_in),
        .fss_edge (fss_edge)
    );

    assign shut = fss_edge ? eff_sel(cfg, prio_mode) : '0;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pcut_chan #(
            .OVLD_CYC (OVLD_CYC),
            .COOL_CYC (COOL_CYC)
        ) u_chan (
            .clk         (clk),
            .rst         (rst),
            .ovl         (ovl_in[ch]),
            .ilim        (ilim_in[ch]),
            .cut_dis     (cfg.cut_dis[ch]),
            .mask_chg    (mask_chg[ch]),
            .shut        (shut[ch]),
            .partner_cut (cut_fire[ch ^ 1]),
            .pair_en     (pair_cut[ch / 2]),
            .pwr_req     (pwr_req[ch]),
            .det_ok      (det_ok[ch]),
            .flag_clr    (flag_clr[ch]),
            .cut_fire    (cut_fire[ch]),
            .pwr_en      (pwr_en[ch]),
            .fault_flag  (fault_flag[ch]),
            .clr_pulse   (clr_pulse[ch]),
            .cool_busy   (cool_busy[ch])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        a_r10_pair_both_off: assert property (@(posedge clk) disable iff (rst)
            pair_cut[p] && (cut_fire[2*p] || cut_fire[2*p+1])
            |=> !pwr_en[2*p] && !pwr_en[2*p+1]);
    end

    a_r8_prio_blocks: assert property (@(posedge clk) disable iff (rst)
        prio_mode && fss_edge |=> clr_pulse == '0);

endmodule

// File: tb/pcut_fss_ctrl_tb.sv
module pcut_fss_ctrl_tb;

    localparam int OV = 8;
    localparam int CL = 20;

    logic       clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic       cfg_wr;
    logic [7:0] cfg_addr, cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       prio_mode;
    logic [1:0] pair_cut;
    logic       fss_in;
    logic [3:0] ovl_in, ilim_in, flag_clr, pwr_req, det_ok;
    logic [3:0] pwr_en, fault_flag, clr_pulse, cool_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pcut_fss_ctrl #(.OVLD_CYC(OV), .COOL_CYC(CL)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prio_mode(prio_mode),
        .pair_cut(pair_cut), .fss_in(fss_in), .ovl_in(ovl_in), .ilim_in(ilim_in),
        .flag_clr(flag_clr), .pwr_req(pwr_req), .det_ok(det_ok), .pwr_en(pwr_en),
        .fault_flag(fault_flag), .clr_pulse(clr_pulse), .cool_busy(cool_busy)
    );

    // behavioural reference
    bit [7:0] m_cfg;
    bit [3:0] m_pwr, m_flag, m_clr;
    int       m_cnt [4];
    int       m_cool[4];
    bit       m_s0, m_s1, m_s2;

    always @(posedge clk) begin : model
        bit [3:0] sel, shut, fire, cutf, kill, mchg;
        bit edg;
        if (rst) begin
            m_cfg = 0; m_pwr = 0; m_flag = 0; m_clr = 0;
            m_s0 = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_cool[i] = 0; end
        end else begin
            edg = m_s1 && !m_s2;
            sel = prio_mode ? 4'h0 : m_cfg[7:4];
            for (int i = 0; i < 4; i++) begin
                fire[i] = ovl_in[i] && m_pwr[i] && (m_cnt[i] == OV - 1);
                cutf[i] = fire[i] && !m_cfg[i];
                mchg[i] = cfg_wr && (cfg_addr == 8'h15) && (cfg_wdata[i] != m_cfg[i]);
                shut[i] = edg && sel[i];
            end
            for (int i = 0; i < 4; i++)
                kill[i] = m_pwr[i] && (cutf[i] || (pair_cut[i/2] && cutf[i^1]) || ilim_in[i]);
            for (int i = 0; i < 4; i++) begin
                if (shut[i] || mchg[i] || !ovl_in[i] || !m_pwr[i]) m_cnt[i] = 0;
                else if (m_cnt[i] != OV - 1) m_cnt[i] = m_cnt[i] + 1;
                if (shut[i]) m_flag[i] = 0;
                else if (fire[i]) m_flag[i] = 1;
                else if (flag_clr[i]) m_flag[i] = 0;
                m_clr[i] = shut[i];
                if (shut[i] || kill[i]) m_pwr[i] = 0;
                else if (pwr_req[i] && det_ok[i] && m_cool[i] == 0) m_pwr[i] = 1;
                if (kill[i]) m_cool[i] = CL;
                else if (m_cool[i] > 0) m_cool[i] = m_cool[i] - 1;
            end
            if (cfg_wr && cfg_addr == 8'h15) m_cfg = cfg_wdata;
            m_s2 = m_s1; m_s1 = m_s0; m_s0 = fss_in;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit [3:0] busy;
        if (!rst && !done) begin
            for (int i = 0; i < 4; i++) busy[i] = (m_cool[i] != 0);
            chk("R3 pwr_en model",     pwr_en,     m_pwr);
            chk("R2 fault_flag model", fault_flag, m_flag);
            chk("R7 clr_pulse model",  clr_pulse,  m_clr);
            chk("R9 cool_busy model",  cool_busy,  busy);
            chk("R1 cfg_rdata model",  cfg_rdata,  (cfg_addr == 8'h15) ? m_cfg : 8'h00);
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_wr = 0; cfg_addr = 8'h15; cfg_wdata = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        rst = 1; cfg_wr = 0; cfg_addr = 8'h15; cfg_wdata = 0; prio_mode = 0;
        pair_cut = 0; fss_in = 0; ovl_in = 0; ilim_in = 0; flag_clr = 0;
        pwr_req = 0; det_ok = 0;
        step(3); rst = 0; step(1);
        chk("R1 reset cfg", cfg_rdata, 8'h00);
        chk("R1 reset pwr", pwr_en, 4'h0);
        chk("R1 reset flag", fault_flag, 4'h0);

        wr(8'h14, 8'hFF);
        chk("R1 other address ignored", cfg_rdata, 8'h00);
        wr(8'h15, 8'h00);

        pwr_req = 4'hF; step(2);
        chk("R11 no detection no power", pwr_en, 4'h0);
        det_ok = 4'hF; step(1);
        chk("R11 power on", pwr_en, 4'hF);
        pwr_req = 0; det_ok = 0;

        ovl_in = 4'h1; step(OV - 1); ovl_in = 0; step(1);
        chk("R2 short overload no flag", fault_flag, 4'h0);
        ovl_in = 4'h1; step(OV - 1);
        chk("R2 one cycle early", fault_flag, 4'h0);
        step(1);
        chk("R2 flag at timeout", fault_flag, 4'h1);
        chk("R3 power cut", pwr_en, 4'hE);
        chk("R3 cool-down started", cool_busy, 4'h1);
        ovl_in = 0;

        flag_clr = 4'h1; step(1); flag_clr = 0;
        chk("R12 flag cleared", fault_flag, 4'h0);
        pwr_req = 4'h1; det_ok = 4'hF; step(1);
        chk("R11 refused in cool-down", pwr_en[0], 0);
        step(CL);
        chk("R11 granted after cool-down", pwr_en[0], 1);
        pwr_req = 0;

        wr(8'h15, 8'h02);
        ovl_in = 4'h2; step(OV + 3);
        chk("R4 masked flag set", fault_flag[1], 1);
        chk("R4 masked power kept", pwr_en[1], 1);
        ilim_in = 4'h2; step(1); ilim_in = 0; ovl_in = 0;
        chk("R6 current limit cuts masked channel", pwr_en[1], 0);
        flag_clr = 4'hF; step(1); flag_clr = 0;

        ovl_in = 4'h4; step(OV - 2);
        wr(8'h15, 8'h04);
        step(OV - 2);
        chk("R5 timer restarted", fault_flag[2], 0);
        step(2);
        chk("R5 flag after restarted timeout", fault_flag[2], 1);
        ovl_in = 0;
        flag_clr = 4'hF; step(1); flag_clr = 0;

        ilim_in = 4'h1; step(1); ilim_in = 0;
        wr(8'h15, 8'h54);
        fss_in = 1; step(2);
        chk("R7 synchroniser latency", pwr_en[2], 1);
        step(1);
        chk("R7 selected channels off", pwr_en, 4'h8);
        chk("R7 clear pulses", clr_pulse, 4'h5);
        chk("R9 cool-down survives shutdown", cool_busy[0], 1);
        step(1);
        chk("R7 pulse single cycle", clr_pulse, 4'h0);
        chk("R8 unselected channel kept", pwr_en[3], 1);
        fss_in = 0; step(2);

        pwr_req = 4'h4; step(1); pwr_req = 0;
        wr(8'h15, 8'hF4);
        prio_mode = 1; fss_in = 1; step(3);
        chk("R8 priority mode no clear", clr_pulse, 4'h0);
        chk("R8 priority mode power kept", pwr_en[3:2], 2'b11);
        step(1); fss_in = 0; step(2); prio_mode = 0;

        wr(8'h15, 8'h00);
        pair_cut = 2'b10; ovl_in = 4'h8; step(OV);
        chk("R10 pair both off", pwr_en[3:2], 2'b00);
        chk("R10 only overloaded flag", fault_flag[3:2], 2'b10);
        ovl_in = 0; step(CL + 2);
        pair_cut = 0; pwr_req = 4'hC; step(1); pwr_req = 0;
        ovl_in = 4'h8; step(OV);
        chk("R10 unpaired single off", pwr_en[3:2], 2'b01);
        ovl_in = 0; step(5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule